// File: doc/BRIEF.md
# Dual-Lane Complex Add/Accumulate Datapath

This block carries a real lane and an imaginary lane. Each lane holds a 20-bit adder/subtractor and an accumulator register, and each produces one result per clock. Both lanes take two 16-bit two's-complement operands, A and B. The block registers these operands behind active-low load enables. The A enable is shared by both A inputs and the B enable by both B inputs. A 2-bit opcode per lane picks the arithmetic. A shared feedback select substitutes each lane's own accumulator for its fresh A operand, which turns the lanes into complex accumulators for filter or correlation work. A shared clear zeroes both accumulators.

For butterfly-style work, a delay select feeds the real lane's A operand from an eight-stage deskew line. This lets data that skipped an external multiplier line up again with data that went through it. The results leave the block at their full 20-bit width, each with a registered overflow bit. The surrounding logic does any scaling to a narrower output.

Top module: `cacc_dual`

## Requirements
- R1: Opcode encoding per lane: 2'b00 gives A+B, 2'b01 gives A−B, 2'b10 gives B−A, 2'b11 passes A unchanged.
- R2: The real and imaginary lanes take separate opcodes, so in the same cycle they may perform different operations.
- R3: While the feedback select is high, each lane's A operand is its own accumulator value and not its A input register. Feedback takes precedence over the delay select.
- R4: A registered clear loads zero into both accumulators and clears both overflow bits. It overrides the selected operation.
- R5: Data and control inputs present before clock edge k are captured at edge k, and they determine the results and overflow bits visible after edge k+1.
- R6: An A or B input register loads only on an edge where its active-low enable is low. Otherwise it keeps its value.
- R7: While the delay select is high and feedback is low, the real lane's A operand is the value its A input register held 8 clocks earlier. The imaginary lane is unaffected.
- R8: The 16-bit operands are sign-extended to 20 bits. Bit 15 of A and bit 15 of B carry the same weight.
- R9: A lane's overflow bit is 1 exactly when its exact signed result falls outside the 20-bit range. The result register then holds the wrapped 20-bit value.
- R10: Synchronous reset clears the input registers, control registers, deskew line, accumulators and overflow bits.
- R11: A new pair of results is produced on every clock, with no stall between operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| a_re_i | input | 16 | Real lane A operand |
| a_im_i | input | 16 | Imaginary lane A operand |
| b_re_i | input | 16 | Real lane B operand |
| b_im_i | input | 16 | Imaginary lane B operand |
| ce_a_n | input | 1 | Active-low load enable for both A registers |
| ce_b_n | input | 1 | Active-low load enable for both B registers |
| op_re_i | input | 2 | Real lane opcode |
| op_im_i | input | 2 | Imaginary lane opcode |
| clr_i | input | 1 | Clear of both accumulators |
| fb_sel_i | input | 1 | Feedback select for both lanes |
| del_sel_i | input | 1 | Deskew select for the real lane's A operand |
| res_re_o | output | 20 | Real accumulator / result |
| res_im_o | output | 20 | Imaginary accumulator / result |
| ovf_re_o | output | 1 | Real lane overflow |
| ovf_im_o | output | 1 | Imaginary lane overflow |

## Verification
The bench builds the block with its defaults: 16-bit operands, 20-bit lanes and an 8-stage deskew line. With these values, feedback accumulation of the largest positive or negative operand wraps the 20-bit range within about sixteen clocks, so both overflow directions are reached quickly. The short deskew line lets each cycle's delayed operand be told apart from the current one while the input varies every clock. Long random runs mix every opcode pair, feedback, deskew, clear and held enables, which reaches the orderings where several controls change at once.

// File: rtl/cacc_pkg.sv
package cacc_pkg;

    localparam int DEF_IN_W   = 16;
    localparam int DEF_ACC_W  = 20;
    localparam int DEF_DESKEW = 8;

    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_SUB  = 2'b01,
        OP_RSUB = 2'b10,
        OP_PASS = 2'b11
    } op_e;

    typedef struct packed {
        op_e  op_re;
        op_e  op_im;
        logic clr;
        logic fb;
        logic del;
    } ctrl_t;

    localparam int NUM_LANES = 2;
    localparam int LANE_RE   = 0;
    localparam int LANE_IM   = 1;

endpackage

// File: rtl/cacc_in_stage.sv
module cacc_in_stage
    import cacc_pkg::*;
#(
    parameter int IN_W = DEF_IN_W
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_LANES-1:0][IN_W-1:0]    a_d,
    input  logic [NUM_LANES-1:0][IN_W-1:0]    b_d,
    input  logic                              ce_a_n,
    input  logic                              ce_b_n,
    input  ctrl_t                             ctrl_d,
    output logic [NUM_LANES-1:0][IN_W-1:0]    a_q,
    output logic [NUM_LANES-1:0][IN_W-1:0]    b_q,
    output ctrl_t                             ctrl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
        end else if (!ce_a_n) begin
            a_q <= a_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            b_q <= '0;
        end else if (!ce_b_n) begin
            b_q <= b_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '{op_re: OP_ADD, op_im: OP_ADD, clr: 1'b0, fb: 1'b0, del: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    // R6: a held enable keeps the operand registers unchanged
    a_r6_hold_a: assert property (@(posedge clk) disable iff (rst)
        ce_a_n |=> $stable(a_q));
    a_r6_hold_b: assert property (@(posedge clk) disable iff (rst)
        ce_b_n |=> $stable(b_q));

endmodule

// File: rtl/cacc_deskew.sv
module cacc_deskew
    import cacc_pkg::*;
#(
    parameter int W     = DEF_IN_W,
    parameter int DEPTH = DEF_DESKEW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    localparam int LAST = DEPTH - 1;

    logic [DEPTH-1:0][W-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q[0] <= '0;
        end else begin
            stage_q[0] <= din;
        end
    end

    for (genvar s = 1; s < DEPTH; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q[s] <= '0;
            end else begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign dout = stage_q[LAST];

endmodule

// File: rtl/cacc_lane.sv
module cacc_lane
    import cacc_pkg::*;
#(
    parameter int IN_W  = DEF_IN_W,
    parameter int ACC_W = DEF_ACC_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [IN_W-1:0]         a_in,
    input  logic [IN_W-1:0]         a_dly,
    input  logic                    use_dly,
    input  logic [IN_W-1:0]         b_in,
    input  op_e                     op,
    input  logic                    clr,
    input  logic                    fb,
    output logic [ACC_W-1:0]        acc_o,
    output logic                    ovf_o
);

    localparam int EXT_W = ACC_W + 1;
    localparam int PAD_W = ACC_W - IN_W;

    logic [ACC_W-1:0] acc_q;
    logic             ovf_q;
    logic [IN_W-1:0]  a_raw;
    logic [ACC_W-1:0] a_ext;
    logic [ACC_W-1:0] b_ext;
    logic [ACC_W-1:0] a_opnd;
    logic [EXT_W-1:0] x_w;
    logic [EXT_W-1:0] y_w;
    logic [EXT_W-1:0] sum_w;
    logic             wrap;

    always_comb begin
        a_raw  = use_dly ? a_dly : a_in;
        a_ext  = {{PAD_W{a_raw[IN_W-1]}}, a_raw};
        b_ext  = {{PAD_W{b_in[IN_W-1]}}, b_in};
        a_opnd = fb ? acc_q : a_ext;
        x_w    = {a_opnd[ACC_W-1], a_opnd};
        y_w    = {b_ext[ACC_W-1], b_ext};
        unique case (op)
            OP_ADD:  sum_w = x_w + y_w;
            OP_SUB:  sum_w = x_w - y_w;
            OP_RSUB: sum_w = y_w - x_w;
            default: sum_w = x_w;
        endcase
        wrap = sum_w[EXT_W-1] ^ sum_w[ACC_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            acc_q <= sum_w[ACC_W-1:0];
            ovf_q <= wrap;
        end
    end

    assign acc_o = acc_q;
    assign ovf_o = ovf_q;

    // R4: clear leaves a zero accumulator and no overflow
    a_r4_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clr |=> (acc_q == '0) && !ovf_q);

    // R1: passing a fresh operand loads its sign-extended value
    a_r1_pass_fresh: assert property (@(posedge clk) disable iff (rst)
        (!clr && !fb && op == OP_PASS) |=> (acc_q == $past(a_ext)) && !ovf_q);

    // R3: passing the fed-back operand keeps the accumulator unchanged
    a_r3_fb_hold: assert property (@(posedge clk) disable iff (rst)
        (!clr && fb && op == OP_PASS) |=> $stable(acc_q));

endmodule

// File: rtl/cacc_dual.sv
module cacc_dual
    import cacc_pkg::*;
#(
    parameter int IN_W   = DEF_IN_W,
    parameter int ACC_W  = DEF_ACC_W,
    parameter int DESKEW = DEF_DESKEW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IN_W-1:0]   a_re_i,
    input  logic [IN_W-1:0]   a_im_i,
    input  logic [IN_W-1:0]   b_re_i,
    input  logic [IN_W-1:0]   b_im_i,
    input  logic              ce_a_n,
    input  logic              ce_b_n,
    input  logic [1:0]        op_re_i,
    input  logic [1:0]        op_im_i,
    input  logic              clr_i,
    input  logic              fb_sel_i,
    input  logic              del_sel_i,
    output logic [ACC_W-1:0]  res_re_o,
    output logic [ACC_W-1:0]  res_im_o,
    output logic              ovf_re_o,
    output logic              ovf_im_o
);

    logic [NUM_LANES-1:0][IN_W-1:0]  a_d;
    logic [NUM_LANES-1:0][IN_W-1:0]  b_d;
    logic [NUM_LANES-1:0][IN_W-1:0]  a_q;
    logic [NUM_LANES-1:0][IN_W-1:0]  b_q;
    logic [NUM_LANES-1:0][ACC_W-1:0] acc;
    logic [NUM_LANES-1:0]            ovf;
    logic [IN_W-1:0]                 a_re_dly;
    ctrl_t                           ctrl_d;
    ctrl_t                           ctrl_q;

    always_comb begin
        a_d[LANE_RE]  = a_re_i;
        a_d[LANE_IM]  = a_im_i;
        b_d[LANE_RE]  = b_re_i;
        b_d[LANE_IM]  = b_im_i;
        ctrl_d.op_re  = op_e'(op_re_i);
        ctrl_d.op_im  = op_e'(op_im_i);
        ctrl_d.clr    = clr_i;
        ctrl_d.fb     = fb_sel_i;
        ctrl_d.del    = del_sel_i;
    end

    cacc_in_stage #(.IN_W(IN_W)) u_in (
        .clk    (clk),
        .rst    (rst),
        .a_d    (a_d),
        .b_d    (b_d),
        .ce_a_n (ce_a_n),
        .ce_b_n (ce_b_n),
        .ctrl_d (ctrl_d),
        .a_q    (a_q),
        .b_q    (b_q),
        .ctrl_q (ctrl_q)
    );

    cacc_deskew #(.W(IN_W), .DEPTH(DESKEW)) u_dsk (
        .clk  (clk),
        .rst  (rst),
        .din  (a_q[LANE_RE]),
        .dout (a_re_dly)
    );

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        cacc_lane #(.IN_W(IN_W), .ACC_W(ACC_W)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .a_in    (a_q[l]),
            .a_dly   ((l == LANE_RE) ? a_re_dly : a_q[l]),
            .use_dly ((l == LANE_RE) ? ctrl_q.del : 1'b0),
            .b_in    (b_q[l]),
            .op      ((l == LANE_RE) ? ctrl_q.op_re : ctrl_q.op_im),
            .clr     (ctrl_q.clr),
            .fb      (ctrl_q.fb),
            .acc_o   (acc[l]),
            .ovf_o   (ovf[l])
        );
    end

    assign res_re_o = acc[LANE_RE];
    assign res_im_o = acc[LANE_IM];
    assign ovf_re_o = ovf[LANE_RE];
    assign ovf_im_o = ovf[LANE_IM];

    // R5: a clear presented at the ports shows as zero two edges later
    a_r5_clear_latency: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !rst) ##1 !rst |=> (res_re_o == '0) && (res_im_o == '0));

endmodule

// File: tb/tb_cacc_dual.sv
`timescale 1ns/1ps
module tb_cacc_dual;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0;
    logic        ce_a_n = 1'b0, ce_b_n = 1'b0;
    logic [1:0]  op_re = 2'b00, op_im = 2'b00;
    logic        clr = 1'b0, fb = 1'b0, del = 1'b0;
    logic [19:0] res_re, res_im;
    logic        ovf_re, ovf_im;

    int errors = 0;
    int checks = 0;
    int ovf_seen = 0;
    string cur_req = "R10";

    // reference state
    int m_are, m_aim, m_bre, m_bim;
    int m_opre, m_opim;
    bit m_clr, m_fb, m_del;
    int acc_re, acc_im;
    bit ov_re, ov_im;
    int dq[$];

    always #2.5 clk = ~clk;

    cacc_dual dut (
        .clk(clk), .rst(rst),
        .a_re_i(a_re), .a_im_i(a_im), .b_re_i(b_re), .b_im_i(b_im),
        .ce_a_n(ce_a_n), .ce_b_n(ce_b_n),
        .op_re_i(op_re), .op_im_i(op_im),
        .clr_i(clr), .fb_sel_i(fb), .del_sel_i(del),
        .res_re_o(res_re), .res_im_o(res_im),
        .ovf_re_o(ovf_re), .ovf_im_o(ovf_im)
    );

    function automatic int sx16(logic [15:0] v);
        return int'($signed(v));
    endfunction

    function automatic int wrap20(int e);
        int m;
        m = e & 32'h000F_FFFF;
        if (m >= 524288) m = m - 1048576;
        return m;
    endfunction

    function automatic int exact(int op, int a, int b);
        case (op)
            0: return a + b;
            1: return a - b;
            2: return b - a;
            default: return a;
        endcase
    endfunction

    task automatic model_reset();
        m_are = 0; m_aim = 0; m_bre = 0; m_bim = 0;
        m_opre = 0; m_opim = 0; m_clr = 0; m_fb = 0; m_del = 0;
        acc_re = 0; acc_im = 0; ov_re = 0; ov_im = 0;
        dq.delete();
        for (int i = 0; i < 8; i++) dq.push_back(0);
    endtask

    task automatic model_step();
        int ar, ai, er, ei;
        if (rst) begin
            model_reset();
            return;
        end
        ar = m_fb ? acc_re : (m_del ? dq[0] : m_are);
        ai = m_fb ? acc_im : m_aim;
        er = exact(m_opre, ar, m_bre);
        ei = exact(m_opim, ai, m_bim);
        if (m_clr) begin
            acc_re = 0; acc_im = 0; ov_re = 0; ov_im = 0;
        end else begin
            acc_re = wrap20(er); ov_re = (er > 524287) || (er < -524288);
            acc_im = wrap20(ei); ov_im = (ei > 524287) || (ei < -524288);
        end
        dq.push_back(m_are);
        void'(dq.pop_front());
        if (!ce_a_n) begin m_are = sx16(a_re); m_aim = sx16(a_im); end
        if (!ce_b_n) begin m_bre = sx16(b_re); m_bim = sx16(b_im); end
        m_opre = int'(op_re); m_opim = int'(op_im);
        m_clr = clr; m_fb = fb; m_del = del;
    endtask

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic compare();
        chk(cur_req, "res_re", int'($signed(res_re)), acc_re);
        chk(cur_req, "res_im", int'($signed(res_im)), acc_im);
        chk(cur_req, "ovf_re", int'(ovf_re), int'(ov_re));
        chk(cur_req, "ovf_im", int'(ovf_im), int'(ov_im));
        if (ovf_re || ovf_im) ovf_seen++;
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic set_ops(int o_re, int o_im);
        op_re = 2'(o_re); op_im = 2'(o_im);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        model_reset();
        @(negedge clk);
        repeat (3) cyc();
        rst = 1'b0;
        // R10: state right after reset is all zero
        cur_req = "R10";
        compare();

        // R1: each opcode with fixed operands
        cur_req = "R1";
        a_re = 16'd1000; b_re = 16'd300; a_im = 16'd77; b_im = 16'd900;
        for (int o = 0; o < 4; o++) begin
            set_ops(o, o);
            repeat (3) cyc();
        end

        // R2: different opcodes per lane in the same cycle
        cur_req = "R2";
        for (int i = 0; i < 20; i++) begin
            set_ops(i % 4, (i + 1 + i / 4) % 4);
            a_re = 16'($urandom); a_im = 16'($urandom);
            b_re = 16'($urandom); b_im = 16'($urandom);
            cyc();
        end

        // R8: extreme negative and positive operands
        cur_req = "R8";
        set_ops(0, 1);
        a_re = 16'h8000; b_re = 16'h8000; a_im = 16'h8000; b_im = 16'h7FFF;
        repeat (3) cyc();
        set_ops(2, 3);
        a_re = 16'hFFFF; b_re = 16'h7FFF; a_im = 16'hFFFE; b_im = 16'h0001;
        repeat (3) cyc();

        // R3: feedback accumulation
        cur_req = "R3";
        set_ops(0, 1);
        a_re = 16'd10; a_im = 16'd20; b_re = 16'd5; b_im = 16'd7;
        cyc();
        fb = 1'b1; del = 1'b1;
        repeat (10) cyc();
        set_ops(3, 3);
        repeat (3) cyc();
        del = 1'b0;

        // R4: clear overrides accumulation
        cur_req = "R4";
        set_ops(0, 0);
        clr = 1'b1;
        cyc();
        clr = 1'b0;
        repeat (4) cyc();

        // R9: accumulate to positive and negative wrap
        cur_req = "R9";
        b_re = 16'h7FFF; b_im = 16'h8000;
        set_ops(0, 0);
        repeat (25) cyc();
        set_ops(2, 1);
        repeat (25) cyc();
        chk("R9", "overflow observed", int'(ovf_seen > 0), 1);
        fb = 1'b0;

        // R6: held enables keep operand registers
        cur_req = "R6";
        set_ops(3, 0);
        a_re = 16'd111; a_im = 16'd222; b_re = 16'd3; b_im = 16'd4;
        repeat (2) cyc();
        ce_a_n = 1'b1; ce_b_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            a_re = 16'($urandom); a_im = 16'($urandom);
            b_re = 16'($urandom); b_im = 16'($urandom);
            cyc();
        end
        ce_a_n = 1'b0; ce_b_n = 1'b0;
        repeat (2) cyc();

        // R7: deskew on the real lane's A operand
        cur_req = "R7";
        set_ops(3, 3);
        del = 1'b1;
        for (int i = 0; i < 24; i++) begin
            a_re = 16'(i * 1000 + 7); a_im = 16'(i * 3);
            cyc();
        end
        set_ops(1, 0);
        for (int i = 0; i < 12; i++) begin
            a_re = 16'($urandom); b_re = 16'($urandom);
            cyc();
        end
        del = 1'b0;

        // R5 / R11: every control changing every cycle
        cur_req = "R5";
        for (int i = 0; i < 300; i++) begin
            if (i == 150) cur_req = "R11";
            a_re = 16'($urandom); a_im = 16'($urandom);
            b_re = 16'($urandom); b_im = 16'($urandom);
            set_ops(int'($urandom % 4), int'($urandom % 4));
            ce_a_n = ($urandom % 4) == 0;
            ce_b_n = ($urandom % 4) == 0;
            clr = ($urandom % 16) == 0;
            fb = ($urandom % 2) == 0;
            del = ($urandom % 2) == 0;
            cyc();
        end
        clr = 1'b0; fb = 1'b0; del = 1'b0; ce_a_n = 1'b0; ce_b_n = 1'b0;
        repeat (3) cyc();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule